// File: doc/BRIEF.md
# Two-Axis Position Read and Clear Port

This block connects two position values, one for the X axis and one for the Y axis, to a host controller over a shared 16-bit data bus. The host places a 3-bit code on its address lines. Each code does one of three things. It puts one axis position on the bus. It sends a clear command to one axis accumulator. Or it leaves the bus floating so that other peripherals on the same lines can use it.

The address is captured on the system clock. The decoded result is registered once more before it reaches the pins. The bus value, the output enable and the clear strobes therefore appear on the second rising edge after the host drives the code.

A clear strobe is edge-detected. It lasts one clock cycle each time a clear code is newly applied, however long the host holds that code. The accumulators are outside this block. Only their values and the strobes cross its boundary.

Top module: `pos_bus_port`

## Requirements
- R1: While reset is high, and on the first cycle after it, `bus_oe` is 0, `bus_data` is all high impedance, and `clr_x` and `clr_y` are 0.
- R2: Address 3'b101 drives `x_pos` onto `bus_data` with `bus_oe` = 1. The result appears on the second rising edge after the code is applied.
- R3: Address 3'b110 drives `y_pos` onto `bus_data` with `bus_oe` = 1, with the same two-edge latency.
- R4: Address 3'b001 produces a one-cycle `clr_x` pulse on the second rising edge after the code is applied. `bus_data` stays at high impedance.
- R5: Address 3'b010 produces a one-cycle `clr_y` pulse with the same latency. `bus_data` stays at high impedance.
- R6: Codes 3'b000, 3'b011, 3'b100 and 3'b111 leave `bus_data` at high impedance with `bus_oe` = 0, and raise neither clear strobe.
- R7: A clear code held for many cycles gives exactly one strobe. Leaving the code and applying it again gives a second strobe.
- R8: While a read code is held, a change on the selected position input shows on `bus_data` one rising edge after the change is sampled.
- R9: A direct change from one clear code to the other gives a strobe for the newly selected axis. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Command/select code from the host |
| x_pos | input | 16 | X axis position value |
| y_pos | input | 16 | Y axis position value |
| clr_x | output | 1 | One-cycle clear strobe for the X accumulator |
| clr_y | output | 1 | One-cycle clear strobe for the Y accumulator |
| bus_oe | output | 1 | High while the block drives the bus |
| bus_data | output | 16 | Tri-state data bus toward the host |

## Verification
A vector table applies all eight address codes, one at a time and separated by an idle code. Each code uses distinct X and Y values. This shows that the two read codes select different axes, that each clear code reaches only its own strobe, and that the four unused codes leave the bus floating.

Directed sequences then cover the edge detection on the clear codes:
- a clear code held for a long time must give exactly one strobe;
- a clear code that is left and reapplied must give a second strobe;
- a direct switch from one clear code to the other must move the strobe to the other axis.

Further directed tests change a position input during a held read, and assert reset in the middle of a read. These check the one-edge tracking and the return of the bus to high impedance.

// File: rtl/pos_bus_pkg.sv
package pos_bus_pkg;
  localparam int AXES   = 2;
  localparam int AXIS_W = (AXES > 1) ? $clog2(AXES) : 1;

  typedef struct packed {
    logic              rd_en;
    logic [AXIS_W-1:0] rd_sel;
    logic [AXES-1:0]   clr_hit;
  } cmd_t;
endpackage

// File: rtl/pos_bus_addr_reg.sv
module pos_bus_addr_reg #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] IDLE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= IDLE;
      addr_prev <= IDLE;
    end else begin
      addr_q    <= addr;
      addr_prev <= addr_q;
    end
  end
endmodule

// File: rtl/pos_bus_decode.sv
module pos_bus_decode
  import pos_bus_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [AXES*ADDR_W-1:0] RD_CODES  = {3'b110, 3'b101},
  parameter logic [AXES*ADDR_W-1:0] CLR_CODES = {3'b010, 3'b001}
) (
  input  logic [ADDR_W-1:0] code,
  output cmd_t              cmd
);
  logic [AXES-1:0] rd_hit;

  for (genvar i = 0; i < AXES; i++) begin : g_hit
    assign rd_hit[i]      = (code == RD_CODES[i*ADDR_W +: ADDR_W]);
    assign cmd.clr_hit[i] = (code == CLR_CODES[i*ADDR_W +: ADDR_W]);
  end

  assign cmd.rd_en = |rd_hit;

  always_comb begin
    cmd.rd_sel = '0;
    for (int i = AXES - 1; i >= 0; i--) begin
      if (rd_hit[i]) cmd.rd_sel = AXIS_W'(i);
    end
  end
endmodule

// File: rtl/pos_bus_clear.sv
module pos_bus_clear
  import pos_bus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [AXES-1:0] hit_now,
  input  logic [AXES-1:0] hit_prev,
  output logic [AXES-1:0] strobe
);
  for (genvar i = 0; i < AXES; i++) begin : g_axis
    always_ff @(posedge clk) begin
      if (rst) strobe[i] <= 1'b0;
      else     strobe[i] <= hit_now[i] & ~hit_prev[i];
    end

    // R4
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      strobe[i] |=> !strobe[i]);
    // R7
    strobe_needs_new_code_chk: assert property (@(posedge clk) disable iff (rst)
      strobe[i] |-> $past(hit_now[i]));
  end

  // R9
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));
endmodule

// File: rtl/pos_bus_drive.sv
module pos_bus_drive
  import pos_bus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [AXIS_W-1:0]      rd_sel,
  input  logic [AXES*DATA_W-1:0] pos_flat,
  output logic                   oe,
  output wire  [DATA_W-1:0]      bus
);
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < AXES; i++) begin
      if (rd_sel == AXIS_W'(i)) pick = pos_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe     <= 1'b0;
      data_q <= '0;
    end else begin
      oe     <= rd_en;
      data_q <= rd_en ? pick : '0;
    end
  end

  assign bus = oe ? data_q : {DATA_W{1'bz}};

  // R2
  oe_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> $past(rd_en));
  // R6
  idle_keeps_float_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> !oe);
endmodule

// File: rtl/pos_bus_port.sv
module pos_bus_port
  import pos_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CODE_RD_X  = 3'b101,
  parameter logic [ADDR_W-1:0] CODE_RD_Y  = 3'b110,
  parameter logic [ADDR_W-1:0] CODE_CLR_X = 3'b001,
  parameter logic [ADDR_W-1:0] CODE_CLR_Y = 3'b010,
  parameter logic [ADDR_W-1:0] CODE_IDLE  = 3'b000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] x_pos,
  input  logic [DATA_W-1:0] y_pos,
  output logic              clr_x,
  output logic              clr_y,
  output logic              bus_oe,
  output wire  [DATA_W-1:0] bus_data
);
  localparam logic [AXES*ADDR_W-1:0] RD_CODES  = {CODE_RD_Y, CODE_RD_X};
  localparam logic [AXES*ADDR_W-1:0] CLR_CODES = {CODE_CLR_Y, CODE_CLR_X};

  logic [ADDR_W-1:0] addr_q, addr_prev;
  cmd_t              cmd_now, cmd_prev;
  logic [AXES-1:0]   strobe;

  pos_bus_addr_reg #(.ADDR_W(ADDR_W), .IDLE(CODE_IDLE)) u_addr (
    .clk(clk), .rst(rst), .addr(addr), .addr_q(addr_q), .addr_prev(addr_prev)
  );

  pos_bus_decode #(.ADDR_W(ADDR_W), .RD_CODES(RD_CODES), .CLR_CODES(CLR_CODES))
    u_dec_now (.code(addr_q), .cmd(cmd_now));

  pos_bus_decode #(.ADDR_W(ADDR_W), .RD_CODES(RD_CODES), .CLR_CODES(CLR_CODES))
    u_dec_prev (.code(addr_prev), .cmd(cmd_prev));

  pos_bus_clear u_clr (
    .clk(clk), .rst(rst),
    .hit_now(cmd_now.clr_hit), .hit_prev(cmd_prev.clr_hit), .strobe(strobe)
  );

  pos_bus_drive #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst(rst),
    .rd_en(cmd_now.rd_en), .rd_sel(cmd_now.rd_sel),
    .pos_flat({y_pos, x_pos}),
    .oe(bus_oe), .bus(bus_data)
  );

  assign clr_x = strobe[0];
  assign clr_y = strobe[1];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bus_oe && !clr_x && !clr_y));
  // R4
  clr_x_source_chk: assert property (@(posedge clk) disable iff (rst)
    clr_x |-> ($past(addr, 2) == CODE_CLR_X && !bus_oe));
  // R5
  clr_y_source_chk: assert property (@(posedge clk) disable iff (rst)
    clr_y |-> ($past(addr, 2) == CODE_CLR_Y && !bus_oe));
  // R2
  read_x_value_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(addr_q) == CODE_RD_X) |-> (bus_data == $past(x_pos)));
  // R3
  read_y_value_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(addr_q) == CODE_RD_Y) |-> (bus_data == $past(y_pos)));
endmodule

// File: tb/pos_bus_port_bench.sv
module pos_bus_port_bench;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 200000;
  localparam int NV     = 8;

  typedef struct packed {
    logic [2:0]  a;
    logic [15:0] x;
    logic [15:0] y;
    logic        oe;
    logic [15:0] d;
    logic        cx;
    logic        cy;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'b101, 16'h1234, 16'hABCD, 1'b1, 16'h1234, 1'b0, 1'b0},
    '{3'b110, 16'h1234, 16'hABCD, 1'b1, 16'hABCD, 1'b0, 1'b0},
    '{3'b001, 16'h0F0F, 16'hF0F0, 1'b0, 16'h0000, 1'b1, 1'b0},
    '{3'b010, 16'h0F0F, 16'hF0F0, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{3'b000, 16'h5555, 16'hAAAA, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'b011, 16'h5555, 16'hAAAA, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'b100, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'b111, 16'h8000, 16'h7FFF, 1'b0, 16'h0000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = 3'b000;
  logic [15:0] x_pos = '0, y_pos = '0;
  logic        clr_x, clr_y, bus_oe;
  wire  [15:0] bus_data;
  int checks = 0, failures = 0, cyc = 0;

  pos_bus_port u_pos_bus_port (
    .clk(clk), .rst(rst), .addr(addr), .x_pos(x_pos), .y_pos(y_pos),
    .clr_x(clr_x), .clr_y(clr_y), .bus_oe(bus_oe), .bus_data(bus_data)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check_out(string req, logic eoe, logic [15:0] ed, logic ecx, logic ecy);
    logic [15:0] ebus;
    ebus = eoe ? ed : 16'hzzzz;
    checks++;
    if (bus_oe !== eoe || bus_data !== ebus || clr_x !== ecx || clr_y !== ecy) begin
      failures++;
      $display("FAIL %s: got oe=%b bus=%h cx=%b cy=%b, expected oe=%b bus=%h cx=%b cy=%b",
               req, bus_oe, bus_data, clr_x, clr_y, eoe, ebus, ecx, ecy);
    end
  endtask

  task automatic check_int(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) addr = 3'b000;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        failures++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int nx, ny;
    // R1: reset state
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 1'b0, 16'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 after reset", 1'b0, 16'h0, 1'b0, 1'b0);
    idle(2);

    // R2 R3 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      addr = VECS[v].a; x_pos = VECS[v].x; y_pos = VECS[v].y;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check_out($sformatf("R2/R3/R4/R5/R6 vec %0d addr=%b", v, VECS[v].a),
                VECS[v].oe, VECS[v].d, VECS[v].cx, VECS[v].cy);
      idle(3);
    end

    // R7: held clear code gives one strobe
    nx = 0;
    @(negedge clk) addr = 3'b001;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (clr_x === 1'b1) nx++;
    end
    check_int("R7 held clear X strobe count", nx, 1);
    check_out("R7 held clear bus float", 1'b0, 16'h0, 1'b0, 1'b0);

    // R7: leave and reapply gives second strobe
    nx = 0;
    @(negedge clk) addr = 3'b000;
    @(negedge clk) addr = 3'b001;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (clr_x === 1'b1) nx++;
    end
    check_int("R7 reapplied clear X strobe count", nx, 1);

    // R9: direct switch X clear -> Y clear
    nx = 0; ny = 0;
    @(negedge clk) addr = 3'b010;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (clr_x === 1'b1) nx++;
      if (clr_y === 1'b1) ny++;
    end
    check_int("R9 switch clear X count", nx, 0);
    check_int("R9 switch clear Y count", ny, 1);
    idle(3);

    // R8: position change during held read
    @(negedge clk);
    addr = 3'b101; x_pos = 16'h0100; y_pos = 16'h0200;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_out("R8 read X initial", 1'b1, 16'h0100, 1'b0, 1'b0);
    x_pos = 16'h0101;
    @(negedge clk);
    check_out("R8 read X tracks one edge", 1'b1, 16'h0101, 1'b0, 1'b0);
    // R3: switch directly to Y read
    addr = 3'b110;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_out("R3 direct switch to Y read", 1'b1, 16'h0200, 1'b0, 1'b0);

    // R1: reset during a read
    rst = 1'b1;
    @(negedge clk);
    check_out("R1 reset during read", 1'b0, 16'h0, 1'b0, 1'b0);
    rst = 1'b0;
    addr = 3'b000;
    idle(2);

    // R6: read ended by unused code floats bus
    @(negedge clk) addr = 3'b101;
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 3'b111;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_out("R6 unused code releases bus", 1'b0, 16'h0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule